// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory into a transmit FIFO under the control of a small table of descriptors held inside it. Each table entry gives the start address of a buffer in memory, the buffer's byte count, and a handful of flag bits. Software fills in an entry through a simple register port and then sets its ready flag. The engine waits on its current entry until that entry is ready. It then reads the buffer one 32-bit word at a time through a bus master port and pushes each word into the FIFO.

When the last word of a buffer has been pushed, the engine writes a result back into the same entry. The ready flag is cleared and the done flag is set. The underrun flag records any starvation of the FIFO during the frame, and the address field holds the end address. The engine then moves on to the next entry. It steps through the table in order and returns to entry 0 after the last one, or straight after any entry that carries the wrap flag. The table is sized by a parameter that can be set anywhere from 2 to 128 entries.

Top module: `tdw_top`

## Requirements
- R1: After reset, `mem_req` and `tx_push` are low, every table word reads back as zero, and the engine starts at entry 0.
- R2: An entry whose ready flag (control bit 0) is clear is never processed. No bus request is issued for it and its control word is left unchanged.
- R3: For an entry of length L bytes and base address B, exactly ceil(L/4) words are pushed. The words are read from addresses B, B+4, B+8 and so on, in that order, and each word reaches `tx_data` unchanged.
- R4: `tx_last` is high together with the final push of a frame and with no other push.
- R5: An entry of length zero completes without any bus read or FIFO push.
- R6: On completion the control word becomes {length[31:16], 12'b0, underrun[3], done[2]=1, wrap[1] kept, ready[0]=0}, and the address word becomes B+L.
- R7: After an entry completes without the wrap flag, the engine moves to the next index, and after index NUM_DESC-1 it moves to index 0.
- R8: After an entry with the wrap flag (control bit 1) completes, the next entry processed is index 0, even if a higher index is also ready.
- R9: While `tx_full` is high no bus request is issued. Reading resumes once it falls.
- R10: The underrun flag (control bit 3) is set only when `tx_empty` is seen high during a frame after its first word was pushed and before its last. It is otherwise written back as 0.
- R11: While a request is not granted, `mem_req` stays high and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+1 | Bit 0 selects the field (0 = control word, 1 = buffer address); the upper bits give the entry index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read of the addressed field |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | DW | Read data |
| tx_push | output | 1 | Push one word into the transmit FIFO |
| tx_data | output | DW | Word pushed |
| tx_last | output | 1 | Marks the final word of a frame |
| tx_full | input | 1 | FIFO cannot accept a word |
| tx_empty | input | 1 | FIFO has drained |

## Verification
The assertions rely on three conditions at the inputs. The memory must return valid data in the same cycle it raises `mem_gnt`. Software must never write an entry in the cycle the engine writes that entry back. `tx_full` must only change between clock edges, so that a request it suppresses cannot also be granted. The stimulus satisfies all three. It drives `mem_gnt` as the request gated by a bench enable, and computes the read data from the address. It changes the FIFO flags and the register port only at falling edges. It writes an entry only while the engine is parked on a different entry, or on an entry that is not ready.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  typedef enum logic [1:0] {
    ST_POLL = 2'd0,
    ST_READ = 2'd1,
    ST_WB   = 2'd2
  } tdw_state_e;

  localparam int ADDR_W   = 32;
  localparam int LEN_W    = 16;
  localparam int LEN_LSB  = 16;
  localparam int FLG_RDY  = 0;
  localparam int FLG_WRAP = 1;
  localparam int FLG_DONE = 2;
  localparam int FLG_URUN = 3;
endpackage

// File: rtl/tdw_desc_table.sv
module tdw_desc_table
  import tdw_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IW = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IW-1:0]     sw_idx,
  input  logic              sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic [IW-1:0]     eng_idx,
  output logic              eng_rdy,
  output logic              eng_wrap,
  output logic [LEN_W-1:0]  eng_len,
  output logic [ADDR_W-1:0] eng_base,
  input  logic              wb_en,
  input  logic [31:0]       wb_ctrl,
  input  logic [ADDR_W-1:0] wb_addr
);
  logic [NUM_DESC-1:0][31:0]       ctrl_all;
  logic [NUM_DESC-1:0][ADDR_W-1:0] addr_all;
  logic [NUM_DESC-1:0]             rdy_all;
  logic [NUM_DESC-1:0]             wrap_all;
  logic [NUM_DESC-1:0][LEN_W-1:0]  len_all;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    logic [31:0]       c_q;
    logic [ADDR_W-1:0] a_q;
    logic              hit_eng;
    logic              hit_sw;

    assign hit_eng = wb_en && (eng_idx == IW'(g));
    assign hit_sw  = sw_we && (sw_idx == IW'(g));

    // engine write-back takes priority over a software write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        a_q <= '0;
      end else if (hit_eng) begin
        c_q <= wb_ctrl;
        a_q <= wb_addr;
      end else if (hit_sw) begin
        if (sw_sel) a_q <= sw_wdata;
        else        c_q <= sw_wdata;
      end
    end

    assign ctrl_all[g] = c_q;
    assign addr_all[g] = a_q;
    assign rdy_all[g]  = c_q[FLG_RDY];
    assign wrap_all[g] = c_q[FLG_WRAP];
    assign len_all[g]  = c_q[LEN_LSB +: LEN_W];
  end

  assign sw_rdata = sw_sel ? addr_all[sw_idx] : ctrl_all[sw_idx];
  assign eng_rdy  = rdy_all[eng_idx];
  assign eng_wrap = wrap_all[eng_idx];
  assign eng_len  = len_all[eng_idx];
  assign eng_base = addr_all[eng_idx];
endmodule

// File: rtl/tdw_engine.sv
module tdw_engine
  import tdw_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int DW = 32,
  localparam int IW = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [IW-1:0]     cur_idx,
  input  logic              cur_rdy,
  input  logic              cur_wrap,
  input  logic [LEN_W-1:0]  cur_len,
  input  logic [ADDR_W-1:0] cur_base,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              tx_push,
  output logic              tx_last,
  output logic              wb_en,
  output logic [31:0]       wb_ctrl,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int BPW = DW / 8;
  localparam logic [LEN_W-1:0] BPW_L = LEN_W'(BPW);
  localparam logic [IW-1:0] IDX_MAX = IW'(NUM_DESC - 1);

  tdw_state_e        state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d, len_q, len_d, step;
  logic              wrap_q, wrap_d, strt_q, strt_d, urun_q, urun_d;
  logic              lst, xfer, ld_en, adv_en, st_en;

  always_comb begin
    lst     = (rem_q <= BPW_L);
    step    = lst ? rem_q : BPW_L;
    mem_req = (state_q == ST_READ) && !tx_full;
    xfer    = mem_req && mem_gnt;
    ld_en   = (state_q == ST_POLL) && cur_rdy;
    adv_en  = xfer;
    st_en   = ld_en || (adv_en && lst) || (state_q == ST_WB);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    len_d   = len_q;
    wrap_d  = wrap_q;
    strt_d  = strt_q;
    urun_d  = urun_q;
    unique case (state_q)
      ST_POLL: begin
        addr_d  = cur_base;
        rem_d   = cur_len;
        len_d   = cur_len;
        wrap_d  = cur_wrap;
        strt_d  = 1'b0;
        urun_d  = 1'b0;
        state_d = (cur_len == '0) ? ST_WB : ST_READ;
      end
      ST_READ: begin
        if (strt_q && tx_empty) urun_d = 1'b1;
        addr_d  = addr_q + ADDR_W'(step);
        rem_d   = rem_q - step;
        strt_d  = 1'b1;
        state_d = ST_WB;
      end
      ST_WB: begin
        state_d = ST_POLL;
        idx_d   = (wrap_q || idx_q == IDX_MAX) ? '0 : idx_q + IW'(1);
      end
      default: state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POLL;
      idx_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      wrap_q  <= 1'b0;
      strt_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      if (st_en) state_q <= state_d;
      if (state_q == ST_WB) idx_q <= idx_d;
      if (ld_en || adv_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        strt_q <= strt_d;
      end
      if (ld_en) begin
        len_q  <= len_d;
        wrap_q <= wrap_d;
      end
      if (ld_en || state_q == ST_READ) urun_q <= urun_d;
    end
  end

  always_comb begin
    wb_ctrl                      = '0;
    wb_ctrl[LEN_LSB +: LEN_W]    = len_q;
    wb_ctrl[FLG_DONE]            = 1'b1;
    wb_ctrl[FLG_WRAP]            = wrap_q;
    wb_ctrl[FLG_URUN]            = urun_q;
  end

  assign wb_en    = (state_q == ST_WB);
  assign wb_addr  = addr_q;
  assign mem_addr = addr_q;
  assign cur_idx  = idx_q;
  assign tx_push  = xfer;
  assign tx_last  = xfer && lst;
endmodule

// File: rtl/tdw_top.sv
module tdw_top
  import tdw_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int DW = 32,
  localparam int IW = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IW:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              tx_push,
  output logic [DW-1:0]     tx_data,
  output logic              tx_last,
  input  logic              tx_full,
  input  logic              tx_empty
);
  logic [1:0]        rs_q;
  logic              rst_i;
  logic [IW-1:0]     cur_idx;
  logic              cur_rdy, cur_wrap, wb_en;
  logic [LEN_W-1:0]  cur_len;
  logic [ADDR_W-1:0] cur_base, wb_addr;
  logic [31:0]       wb_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  tdw_desc_table #(.NUM_DESC(NUM_DESC)) u_tab (
    .clk      (clk),
    .rst_n    (rst_i),
    .sw_we    (reg_we),
    .sw_idx   (reg_addr[IW:1]),
    .sw_sel   (reg_addr[0]),
    .sw_wdata (reg_wdata),
    .sw_rdata (reg_rdata),
    .eng_idx  (cur_idx),
    .eng_rdy  (cur_rdy),
    .eng_wrap (cur_wrap),
    .eng_len  (cur_len),
    .eng_base (cur_base),
    .wb_en    (wb_en),
    .wb_ctrl  (wb_ctrl),
    .wb_addr  (wb_addr)
  );

  tdw_engine #(.NUM_DESC(NUM_DESC), .DW(DW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_i),
    .cur_idx  (cur_idx),
    .cur_rdy  (cur_rdy),
    .cur_wrap (cur_wrap),
    .cur_len  (cur_len),
    .cur_base (cur_base),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .tx_push  (tx_push),
    .tx_last  (tx_last),
    .wb_en    (wb_en),
    .wb_ctrl  (wb_ctrl),
    .wb_addr  (wb_addr)
  );

  assign tx_data = mem_rdata;
endmodule

// File: rtl/tdw_chk.sv
module tdw_chk #(
  parameter int DW = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic        tx_push,
  input logic        tx_last,
  input logic        tx_full
);
  localparam int BPW = DW / 8;

  AST_FULL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !mem_req); // R9

  AST_LAST_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_push); // R4

  AST_PUSH_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (mem_req && mem_gnt)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_last) |=> (mem_addr == $past(mem_addr) + 32'(BPW))); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !tx_full) |=> $stable(mem_addr)); // R11
endmodule

bind tdw_top tdw_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .tx_push  (tx_push),
  .tx_last  (tx_last),
  .tx_full  (tx_full)
);

// File: tb/sim_tdw_top.sv
`timescale 1ns/1ps
module sim_tdw_top;
  localparam int ND = 4;
  localparam int IW = 2;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [IW:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_gnt, tx_push, tx_last;
  logic [31:0] mem_addr, mem_rdata, tx_data;
  logic        tx_full = 1'b0, tx_empty = 1'b0, gnt_en = 1'b1;

  int n_chk = 0, n_bad = 0, cap_n = 0, exp_idx = 0;
  logic [31:0] cap_d [1024];
  logic        cap_l [1024];

  always #4 clk = ~clk;

  assign mem_gnt   = mem_req & gnt_en;
  assign mem_rdata = mem_addr ^ KEY;

  tdw_top #(.NUM_DESC(ND), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_push(tx_push), .tx_data(tx_data), .tx_last(tx_last),
    .tx_full(tx_full), .tx_empty(tx_empty)
  );

  always @(negedge clk) begin
    if (rst_n && tx_push) begin
      if (cap_n < 1024) begin
        cap_d[cap_n] = tx_data;
        cap_l[cap_n] = tx_last;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {IW'(idx), sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int idx, input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_addr = {IW'(idx), sel};
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input int len, input bit urun,
                                      input bit done, input bit wrap, input bit rdy);
    return {16'(len), 12'b0, urun, done, wrap, rdy};
  endfunction

  task automatic prog(input int idx, input logic [31:0] base, input int len, input bit wrap);
    reg_wr(idx, 1'b1, base);
    reg_wr(idx, 1'b0, ctl(len, 1'b0, 1'b0, wrap, 1'b1));
  endtask

  task automatic finish(input int idx, input logic [31:0] base, input int len,
                        input bit wrap, input bit urun, input int start);
    logic [31:0] v;
    bit seen = 1'b0;
    int words = (len + 3) / 4;
    for (int t = 0; t < 400 && !seen; t++) begin
      reg_rd(idx, 1'b0, v);
      seen = v[2];
    end
    chk("R7", "entry processed at expected index", 32'(seen), 32'd1);
    chk("R3", "word count", 32'(cap_n - start), 32'(words));
    for (int k = 0; k < words; k++) begin
      chk("R3", "word data", cap_d[start + k], (base + 32'(4 * k)) ^ KEY);
      chk("R4", "last flag", 32'(cap_l[start + k]), 32'(k == words - 1));
    end
    if (len == 0) chk("R5", "zero length pushes", 32'(cap_n - start), 32'd0);
    chk("R6", "status word", v, ctl(len, urun, 1'b1, wrap, 1'b0));
    chk("R10", "underrun flag", 32'(v[3]), 32'(urun));
    reg_rd(idx, 1'b1, v);
    chk("R6", "end address", v, base + 32'(len));
  endtask

  task automatic run_frame(input int idx, input logic [31:0] base, input int len,
                           input bit wrap, input bit urun);
    int start = cap_n;
    prog(idx, base, len, wrap);
    finish(idx, base, len, wrap, urun, start);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int start;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1", "tx_push after reset", 32'(tx_push), 32'd0);
    for (int i = 0; i < ND; i++) begin
      reg_rd(i, 1'b0, v); chk("R1", "control word reset", v, 32'd0);
      reg_rd(i, 1'b1, v); chk("R1", "address word reset", v, 32'd0);
    end

    // R2: entry without ready flag is ignored
    reg_wr(0, 1'b1, 32'h0000_4000);
    reg_wr(0, 1'b0, ctl(8, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    chk("R2", "no pushes for unready entry", 32'(cap_n), 32'd0);
    chk("R2", "no request for unready entry", 32'(mem_req), 32'd0);
    reg_rd(0, 1'b0, v);
    chk("R2", "unready control word untouched", v, ctl(8, 1'b0, 1'b0, 1'b0, 1'b0));

    // R3..R7: sweep of lengths across the ring
    for (int len = 0; len < 14; len++) begin
      run_frame(exp_idx, 32'h0001_0000 + 32'(len * 256), len, 1'b0, 1'b0);
      exp_idx = (exp_idx + 1) % ND;
    end

    // R8: wrap flag sends the engine back to entry 0
    run_frame(exp_idx, 32'h0002_0000, 4, 1'b1, 1'b0);
    exp_idx = 0;
    start = cap_n;
    reg_wr(3, 1'b1, 32'h0003_3000);
    reg_wr(0, 1'b1, 32'h0003_0000);
    reg_wr(3, 1'b0, ctl(4, 1'b0, 1'b0, 1'b0, 1'b1));
    reg_wr(0, 1'b0, ctl(4, 1'b0, 1'b0, 1'b0, 1'b1));
    finish(0, 32'h0003_0000, 4, 1'b0, 1'b0, start);
    chk("R8", "first word after wrap from entry 0", cap_d[start], 32'h0003_0000 ^ KEY);
    reg_rd(3, 1'b0, v);
    chk("R8", "higher ready entry skipped", 32'(v[2]), 32'd0);
    reg_wr(3, 1'b0, 32'd0);
    exp_idx = 1;

    // R9: full FIFO stalls reading
    tx_full = 1'b1;
    start = cap_n;
    prog(1, 32'h0004_0000, 8, 1'b0);
    repeat (15) @(negedge clk);
    chk("R9", "no pushes while full", 32'(cap_n - start), 32'd0);
    chk("R9", "no request while full", 32'(mem_req), 32'd0);
    tx_full = 1'b0;
    finish(1, 32'h0004_0000, 8, 1'b0, 1'b0, start);

    // R11: ungranted request holds
    gnt_en = 1'b0;
    start = cap_n;
    prog(2, 32'h0005_0000, 8, 1'b0);
    repeat (5) @(negedge clk);
    chk("R11", "request held", 32'(mem_req), 32'd1);
    chk("R11", "address held", mem_addr, 32'h0005_0000);
    chk("R11", "no push without grant", 32'(cap_n - start), 32'd0);
    gnt_en = 1'b1;
    finish(2, 32'h0005_0000, 8, 1'b0, 1'b0, start);

    // R10: underrun flag
    tx_empty = 1'b1;
    run_frame(3, 32'h0006_0000, 12, 1'b0, 1'b1);
    run_frame(0, 32'h0006_1000, 4, 1'b0, 1'b0);
    tx_empty = 1'b0;
    run_frame(1, 32'h0006_2000, 8, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule